// File: doc/BRIEF.md
# Implicit-form linear dataflow step engine

This block evaluates one time step of a linear signal-processing dataflow. The dataflow is held in implicit state-space form, with nine constant coefficient matrices fixed as parameters at elaboration. A single `start_i` pulse latches the input vector. The engine then works through the equations one row at a time, using one shared multiplier and one multiply-accumulate per clock.

The rows are handled in a fixed sequence. The intermediate rows come first, and each intermediate may use intermediates already computed in the same step through the strictly-lower part of the dependency matrix, so no inverse is ever formed. The next-state rows follow, and the output rows come last. Zero coefficients are dropped when the block is elaborated, so they cost no cycles. A one-cycle `done_o` pulse marks the point where the outputs are valid and the state register takes its new value.

All values are signed two's complement. Data words are `W` bits wide. Coefficients are `CW` bits wide, with `CF` fractional bits, and `CF` must be at least 1.

Top module: `sif_engine`

## Requirements
- R1: While `rst_n` is low at a clock edge, `busy_o` and `done_o` go to 0, and every word of `y_o` and `state_o` clears to zero.
- R2: A `start_i` seen while idle latches `u_i` and raises `busy_o` on the next cycle. A `start_i` seen while busy has no effect: the step keeps its latched input and its timing.
- R3: One step computes three groups of rows, in this order:
  - t_i = (M·x + N·u)_i − Σ_{j<i} J_ij·t_j, using the t_j already computed in this step;
  - x' = K·t + P·x + Q·u;
  - y = L·t + R·x + S·u, using the old state x and never x'.
- R4: Each row's sum of products (data Q·, coefficients with `CF` fractional bits) is rounded by adding 2^(CF−1) and shifting arithmetically right by `CF`. The low `W` bits are kept, so a result out of range wraps.
- R5: `done_o` rises exactly Σ over rows of max(nonzero coefficients in the row, 1) cycles after the edge that accepts `start_i`. With the default coefficients this is 10 cycles.
- R6: `done_o` is high for exactly one cycle. `y_o` holds the new outputs from that cycle until a later step rewrites them.
- R7: `state_o` changes only in the cycle in which `done_o` is high. There it takes all of x' at once.
- R8: A `start_i` driven in the same cycle as `done_o` is accepted. That new step uses the state just written.
- R9: The diagonal and the upper-triangular entries of J have no effect on any result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begins one step when the engine is idle |
| u_i | input | NU*W | Input vector; word i is at bits [i*W +: W] |
| busy_o | output | 1 | A step is in progress |
| done_o | output | 1 | One-cycle pulse: outputs valid and state updated |
| y_o | output | NY*W | Output vector, word i is at bits [i*W +: W] |
| state_o | output | NX*W | State vector x, word i is at bits [i*W +: W] |

## Verification
Two things can share a clock cycle:
- the edge that commits x' and raises `done_o`;
- the acceptance of the next `start_i`.

The bench provokes this by driving `start_i` in the very cycle `done_o` is observed. It then judges the chained step against a reference model whose state has already advanced. A wrong result shows that the new step read the stale state.

A second collision is a `start_i` arriving mid-step. It is judged by an unchanged latency and unchanged results. Rounding ties of both signs are also checked, along with wrap-around and a second instance whose ignored J entries are filled with junk.

// File: rtl/sif_pkg.sv
// Package: shared row classification for the implicit-form step engine.
// Assumes rows are ordered intermediates, then states, then outputs.
package sif_pkg;

    typedef enum logic [1:0] {
        KIND_INTER = 2'd0,
        KIND_STATE = 2'd1,
        KIND_OUT   = 2'd2
    } row_kind_e;

    // Classify a unified row index into its destination group.
    function automatic row_kind_e kind_of(input int r, input int nt, input int nx);
        if (r < nt)
            return KIND_INTER;
        else if (r < nt + nx)
            return KIND_STATE;
        else
            return KIND_OUT;
    endfunction

endpackage

// File: rtl/sif_coef_tab.sv
// Module: builds the unified coefficient table, one row per equation and one
// column per source (intermediates, states, inputs), plus a nonzero mask.
// Assumes the matrices are flat vectors, with entry (i,j) at index i*cols+j.
// Intermediate rows take the negated strictly-lower part of J; the diagonal
// and upper part of J are never read.
module sif_coef_tab #(
    parameter int NT = 2,
    parameter int NX = 2,
    parameter int NU = 1,
    parameter int NY = 1,
    parameter int CW = 16,
    parameter logic [NT*NT*CW-1:0] J_MAT = '0,
    parameter logic [NT*NX*CW-1:0] M_MAT = '0,
    parameter logic [NT*NU*CW-1:0] N_MAT = '0,
    parameter logic [NX*NT*CW-1:0] K_MAT = '0,
    parameter logic [NX*NX*CW-1:0] P_MAT = '0,
    parameter logic [NX*NU*CW-1:0] Q_MAT = '0,
    parameter logic [NY*NT*CW-1:0] L_MAT = '0,
    parameter logic [NY*NX*CW-1:0] R_MAT = '0,
    parameter logic [NY*NU*CW-1:0] S_MAT = '0
) (
    output logic signed [CW-1:0] coef_o [NT+NX+NY][NT+NX+NU],
    output logic                 nz_o   [NT+NX+NY][NT+NX+NU]
);
    import sif_pkg::*;

    localparam int NR = NT + NX + NY;
    localparam int NC = NT + NX + NU;

    // Coefficient of source column c in equation row r.
    function automatic logic [CW-1:0] coef_at(input int r, input int c);
        logic [CW-1:0] v;
        int            i;
        v = '0;
        case (kind_of(r, NT, NX))
            KIND_INTER: begin
                i = r;
                if (c < NT) begin
                    if (c < r) v = '0 - J_MAT[(i*NT+c)*CW +: CW];
                end else if (c < NT + NX) begin
                    v = M_MAT[(i*NX+(c-NT))*CW +: CW];
                end else begin
                    v = N_MAT[(i*NU+(c-NT-NX))*CW +: CW];
                end
            end
            KIND_STATE: begin
                i = r - NT;
                if (c < NT)           v = K_MAT[(i*NT+c)*CW +: CW];
                else if (c < NT + NX) v = P_MAT[(i*NX+(c-NT))*CW +: CW];
                else                  v = Q_MAT[(i*NU+(c-NT-NX))*CW +: CW];
            end
            default: begin
                i = r - NT - NX;
                if (c < NT)           v = L_MAT[(i*NT+c)*CW +: CW];
                else if (c < NT + NX) v = R_MAT[(i*NX+(c-NT))*CW +: CW];
                else                  v = S_MAT[(i*NU+(c-NT-NX))*CW +: CW];
            end
        endcase
        return v;
    endfunction

    for (genvar r = 0; r < NR; r++) begin : g_row
        for (genvar c = 0; c < NC; c++) begin : g_col
            localparam logic [CW-1:0] CV = coef_at(r, c);
            // Constant table entry and its nonzero flag.
            assign coef_o[r][c] = $signed(CV);
            assign nz_o[r][c]   = (CV != '0);
        end
    end

endmodule

// File: rtl/sif_sched.sv
// Module: walks the nonzero coefficients row by row, one per cycle.
// Assumes nz_i is constant. An all-zero row still takes one cycle, to commit
// its zero result. row_end_o marks the cycle in which the current row's
// result is written.
module sif_sched #(
    parameter int NR = 5,
    parameter int NC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    input  logic nz_i [NR][NC],
    output logic busy_o,
    output logic [((NR > 1) ? $clog2(NR) : 1)-1:0] row_o,
    output logic [((NC > 1) ? $clog2(NC) : 1)-1:0] col_o,
    output logic term_o,
    output logic row_end_o,
    output logic step_end_o
);
    localparam int RIW = (NR > 1) ? $clog2(NR) : 1;
    localparam int CIW = (NC > 1) ? $clog2(NC) : 1;

    logic           busy_q;
    logic [RIW-1:0] row_q;
    logic [CIW-1:0] col_q;
    logic           nxt_found;
    logic [CIW-1:0] nxt_col;
    logic [CIW-1:0] first_nxt;
    logic [CIW-1:0] first0;
    logic           term;

    // Find the current term, the next nonzero in this row, and the first
    // nonzero of the next row and of row zero.
    always_comb begin
        term      = 1'b0;
        nxt_found = 1'b0;
        nxt_col   = '0;
        first_nxt = '0;
        first0    = '0;
        for (int r = 0; r < NR; r++) begin
            for (int c = NC - 1; c >= 0; c--) begin
                if (nz_i[r][c]) begin
                    if (r == int'(row_q)) begin
                        if (c == int'(col_q)) term = busy_q;
                        if (c > int'(col_q)) begin
                            nxt_found = 1'b1;
                            nxt_col   = CIW'(c);
                        end
                    end
                    if (r == int'(row_q) + 1) first_nxt = CIW'(c);
                    if (r == 0) first0 = CIW'(c);
                end
            end
        end
    end

    // Advance the position: start at row zero, step columns, then rows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            row_q  <= '0;
            col_q  <= '0;
        end else if (!busy_q) begin
            if (go_i) begin
                busy_q <= 1'b1;
                row_q  <= '0;
                col_q  <= first0;
            end
        end else if (!nxt_found) begin
            if (int'(row_q) == NR - 1) begin
                busy_q <= 1'b0;
                row_q  <= '0;
                col_q  <= '0;
            end else begin
                row_q <= row_q + 1'b1;
                col_q <= first_nxt;
            end
        end else begin
            col_q <= nxt_col;
        end
    end

    assign busy_o     = busy_q;
    assign row_o      = row_q;
    assign col_o      = col_q;
    assign term_o     = term;
    assign row_end_o  = busy_q && !nxt_found;
    assign step_end_o = busy_q && !nxt_found && (int'(row_q) == NR - 1);

endmodule

// File: rtl/sif_mac.sv
// Module: single shared multiplier with a row accumulator and a rounding
// step. The rounded row result is presented combinationally in the row's
// final cycle, and the accumulator then clears. Assumes CF >= 1.
module sif_mac #(
    parameter int W   = 16,
    parameter int CW  = 16,
    parameter int CF  = 8,
    parameter int NC  = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_en_i,
    input  logic                row_end_i,
    input  logic signed [W-1:0]  opnd_i,
    input  logic signed [CW-1:0] coef_i,
    output logic signed [W-1:0]  res_o
);
    localparam int PW   = W + CW;
    localparam int ACCW = PW + $clog2(NC) + 1;
    localparam logic signed [ACCW-1:0] HALF = ACCW'(1) <<< (CF - 1);

    logic signed [PW-1:0]   prod;
    logic signed [ACCW-1:0] sum;
    logic signed [ACCW-1:0] rnd;
    logic signed [ACCW-1:0] acc_q;

    // Product, running sum and round-half-up of the row result.
    always_comb begin
        prod  = opnd_i * coef_i;
        sum   = acc_q + (acc_en_i ? {{(ACCW-PW){prod[PW-1]}}, prod} : '0);
        rnd   = sum + HALF;
        res_o = rnd[CF +: W];
    end

    // Accumulate terms; clear when the row is committed.
    always_ff @(posedge clk) begin
        if (!rst_n)         acc_q <= '0;
        else if (row_end_i) acc_q <= '0;
        else if (acc_en_i)  acc_q <= sum;
    end

endmodule

// File: rtl/sif_engine.sv
// Module: top of the implicit-form linear dataflow step engine.
// One start computes the intermediates, then the next state, then the
// outputs, one multiply-accumulate per cycle. The state register commits
// in the same edge that raises done. Assumes NY >= 1 and CF >= 1.
module sif_engine #(
    parameter int NT = 2,
    parameter int NX = 2,
    parameter int NU = 1,
    parameter int NY = 1,
    parameter int W  = 16,
    parameter int CW = 16,
    parameter int CF = 8,
    parameter logic [NT*NT*CW-1:0] J_MAT = 64'h0100_FF00_0000_0100,
    parameter logic [NT*NX*CW-1:0] M_MAT = 64'hFFC0_0000_0000_0080,
    parameter logic [NT*NU*CW-1:0] N_MAT = 32'h0000_0100,
    parameter logic [NX*NT*CW-1:0] K_MAT = 64'h0080_0000_0000_0100,
    parameter logic [NX*NX*CW-1:0] P_MAT = 64'h0000_0040_0000_0000,
    parameter logic [NX*NU*CW-1:0] Q_MAT = 32'h0000_0000,
    parameter logic [NY*NT*CW-1:0] L_MAT = 32'h0100_0000,
    parameter logic [NY*NX*CW-1:0] R_MAT = 32'h0080_0000,
    parameter logic [NY*NU*CW-1:0] S_MAT = 16'h0040
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [NU*W-1:0] u_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [NY*W-1:0] y_o,
    output logic [NX*W-1:0] state_o
);
    import sif_pkg::*;

    localparam int NR  = NT + NX + NY;
    localparam int NC  = NT + NX + NU;
    localparam int RIW = (NR > 1) ? $clog2(NR) : 1;
    localparam int CIW = (NC > 1) ? $clog2(NC) : 1;

    logic signed [CW-1:0] coef_tab [NR][NC];
    logic                 nz_tab   [NR][NC];

    logic           busy;
    logic [RIW-1:0] row;
    logic [CIW-1:0] col;
    logic           term;
    logic           row_end;
    logic           step_end;
    logic           go;
    row_kind_e      kind;

    logic signed [W-1:0]  u_q  [NU];
    logic signed [W-1:0]  t_q  [NT];
    logic signed [W-1:0]  x_q  [NX];
    logic signed [W-1:0]  xn_q [NX];
    logic signed [W-1:0]  y_q  [NY];
    logic                 done_q;
    logic signed [W-1:0]  src  [NC];
    logic signed [W-1:0]  opnd;
    logic signed [CW-1:0] coef;
    logic signed [W-1:0]  res;

    sif_coef_tab #(
        .NT(NT), .NX(NX), .NU(NU), .NY(NY), .CW(CW),
        .J_MAT(J_MAT), .M_MAT(M_MAT), .N_MAT(N_MAT),
        .K_MAT(K_MAT), .P_MAT(P_MAT), .Q_MAT(Q_MAT),
        .L_MAT(L_MAT), .R_MAT(R_MAT), .S_MAT(S_MAT)
    ) u_tab (
        .coef_o (coef_tab),
        .nz_o   (nz_tab)
    );

    assign go = start_i && !busy;

    sif_sched #(.NR(NR), .NC(NC)) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (go),
        .nz_i       (nz_tab),
        .busy_o     (busy),
        .row_o      (row),
        .col_o      (col),
        .term_o     (term),
        .row_end_o  (row_end),
        .step_end_o (step_end)
    );

    // Unified source vector: intermediates, then states, then inputs.
    for (genvar c = 0; c < NC; c++) begin : g_src
        if (c < NT) begin : g_t
            assign src[c] = t_q[c];
        end else if (c < NT + NX) begin : g_x
            assign src[c] = x_q[c-NT];
        end else begin : g_u
            assign src[c] = u_q[c-NT-NX];
        end
    end

    // Select the operand and coefficient at the current position.
    always_comb begin
        opnd = '0;
        coef = '0;
        for (int c = 0; c < NC; c++) begin
            if (c == int'(col)) opnd = src[c];
        end
        for (int r = 0; r < NR; r++) begin
            for (int c = 0; c < NC; c++) begin
                if (r == int'(row) && c == int'(col)) coef = coef_tab[r][c];
            end
        end
    end

    assign kind = kind_of(int'(row), NT, NX);

    sif_mac #(.W(W), .CW(CW), .CF(CF), .NC(NC)) u_mac (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en_i  (term),
        .row_end_i (row_end),
        .opnd_i    (opnd),
        .coef_i    (coef),
        .res_o     (res)
    );

    // Latch inputs, commit row results, and move x' into x at the step end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NU; i++) u_q[i]  <= '0;
            for (int i = 0; i < NT; i++) t_q[i]  <= '0;
            for (int i = 0; i < NX; i++) x_q[i]  <= '0;
            for (int i = 0; i < NX; i++) xn_q[i] <= '0;
            for (int i = 0; i < NY; i++) y_q[i]  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= step_end;
            if (go) begin
                for (int i = 0; i < NU; i++) u_q[i] <= u_i[i*W +: W];
            end
            if (row_end) begin
                case (kind)
                    KIND_INTER: for (int i = 0; i < NT; i++) begin
                        if (int'(row) == i) t_q[i] <= res;
                    end
                    KIND_STATE: for (int i = 0; i < NX; i++) begin
                        if (int'(row) == NT + i) xn_q[i] <= res;
                    end
                    default: for (int i = 0; i < NY; i++) begin
                        if (int'(row) == NT + NX + i) y_q[i] <= res;
                    end
                endcase
            end
            if (step_end) begin
                for (int i = 0; i < NX; i++) x_q[i] <= xn_q[i];
            end
        end
    end

    for (genvar i = 0; i < NY; i++) begin : g_yout
        assign y_o[i*W +: W] = y_q[i];
    end
    for (genvar i = 0; i < NX; i++) begin : g_xout
        assign state_o[i*W +: W] = x_q[i];
    end
    assign busy_o = busy;
    assign done_o = done_q;

endmodule

// File: rtl/sif_engine_chk.sv
// Module: protocol checker for the step engine, attached by bind.
// Assumes a synchronous active-low reset held for at least one edge.
module sif_engine_chk #(
    parameter int NX = 2,
    parameter int W  = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic            busy_o,
    input logic            done_o,
    input logic [NX*W-1:0] state_o
);
    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R6
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R7
    state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(state_o));

    // R5
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy_o));

endmodule

bind sif_engine sif_engine_chk #(.NX(NX), .W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .state_o (state_o)
);

// File: tb/test_sif_engine.sv
// Bench: walks a stimulus table through a reference model, then runs
// directed reset, rounding and collision cases.
module test_sif_engine;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [15:0] u;
    logic        busy, done, busy_a, done_a;
    logic [15:0] y, y_a;
    logic [31:0] state, state_a;

    int     checks = 0;
    int     fails  = 0;
    longint mx0 = 0;
    longint mx1 = 0;

    always #5 clk = ~clk;

    sif_engine i_sif_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start), .u_i(u),
        .busy_o(busy), .done_o(done), .y_o(y), .state_o(state)
    );

    // Junk on the J diagonal and upper triangle must not matter (R9).
    sif_engine #(.J_MAT(64'h0500_FF00_7777_0300)) i_sif_engine_alt (
        .clk(clk), .rst_n(rst_n), .start_i(start), .u_i(u),
        .busy_o(busy_a), .done_o(done_a), .y_o(y_a), .state_o(state_a)
    );

    localparam int NV = 10;
    localparam int U_TAB [NV] = '{1, -1, 1000, -3000, 32767, 32767, -32768, 77, 5, -200};
    localparam bit CH_TAB [NV] = '{0, 1, 0, 1, 1, 0, 1, 0, 1, 0};
    localparam bit PK_TAB [NV] = '{0, 0, 1, 0, 0, 1, 0, 0, 0, 1};
    localparam int LAT = 11; // 10 work cycles plus the sampling edge

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint rnd(input longint s);
        longint v;
        v = (s + 128) >>> 8;
        return longint'($signed(v[15:0]));
    endfunction

    // Reference equations for the default coefficients (Q8).
    task automatic model(input longint uu, output longint ey);
        longint t0, t1, n0, n1;
        t0 = rnd(128*mx0 + 256*uu);
        t1 = rnd(256*t0 - 64*mx1);
        n0 = rnd(256*t0);
        n1 = rnd(128*t1 + 64*mx0);
        ey = rnd(256*t1 + 128*mx1 + 64*uu);
        mx0 = n0;
        mx1 = n1;
    endtask

    task automatic run(input logic [15:0] uu, input bit poke, output int lat);
        start = 1'b1;
        u     = uu;
        lat   = 0;
        do begin
            @(negedge clk);
            lat++;
            if (lat == 1) start = 1'b0;
            if (poke && lat == 4) begin start = 1'b1; u = 16'h4321; end
            if (poke && lat == 5) begin start = 1'b0; u = uu; end
        end while (!done && lat < 200);
    endtask

    task automatic step_chk(input int uu, input bit poke, input bit chain);
        int     lat;
        longint ey;
        if (!chain) begin
            @(negedge clk);
            chk("R6 done low after pulse", longint'(done), 0);
            chk("R7 state x0 held while idle", longint'($signed(state[15:0])), mx0);
        end
        run(16'(uu), poke, lat);
        model(longint'(uu), ey);
        chk(poke ? "R2 latency with start while busy" : (chain ? "R8 latency chained" : "R5 latency"),
            longint'(lat), LAT);
        chk(chain ? "R8 y chained" : "R3 y", longint'($signed(y)), ey);
        chk("R3 state x0", longint'($signed(state[15:0])), mx0);
        chk("R3 state x1", longint'($signed(state[31:16])), mx1);
        chk("R9 alt y", longint'($signed(y_a)), ey);
        chk("R9 alt state", longint'($signed(state_a)), longint'($signed({16'(mx1), 16'(mx0)})));
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        u     = '0;
        repeat (4) @(negedge clk);
        chk("R1 busy at reset", longint'(busy), 0);
        chk("R1 done at reset", longint'(done), 0);
        chk("R1 y at reset", longint'(y), 0);
        chk("R1 state at reset", longint'(state), 0);
        rst_n = 1'b1;

        // Hand-computed first steps (R3): y = 320 then 160.
        step_chk(256, 0, 0);
        chk("R3 hand y step 1", longint'($signed(y)), 320);
        step_chk(0, 0, 1);
        chk("R3 hand y step 2", longint'($signed(y)), 160);

        // Table walk: chained starts (R8), mid-step starts (R2), wrap (R4).
        for (int k = 0; k < NV; k++) begin
            step_chk(U_TAB[k], PK_TAB[k], CH_TAB[k]);
        end

        // Reset mid-run clears state (R1), then rounding ties of both signs (R4).
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 state after mid-run reset", longint'(state), 0);
        chk("R1 y after mid-run reset", longint'(y), 0);
        rst_n = 1'b1;
        mx0 = 0;
        mx1 = 0;
        step_chk(-1, 0, 0);
        chk("R4 negative tie x1", longint'($signed(state[31:16])), 0);
        chk("R4 negative y", longint'($signed(y)), -1);
        step_chk(1, 0, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule